// File: doc/BRIEF.md
# Processor Status Trace Output Unit

This unit drives two 4-bit buses toward an external trace probe, and it updates both on every system clock cycle. The status bus carries the core's per-cycle pipeline code. It does not describe the current bus transfer. When the core halts, the status bus is forced to the reserved code 0xF. A manual breakpoint request does not stop the core at once. The halt takes effect only after the instruction that is executing reports completion. A resume input releases the halt.

The debug-data bus normally shows the breakpoint status bits. A capture request loads a 32-bit value, and the unit then streams that value out as eight nibbles, least significant nibble first. A two-bit mode field decides whether address captures and operand captures are accepted. The dedicated write-debug-data request is always accepted. If a request arrives while a value is streaming, one request can wait in a holding register. Any further request is dropped while that register is full.

Halt controller states: RUN (status follows the core), PENDING (a breakpoint is requested and the unit waits for instruction completion), STOPPED (status is 0xF). Its transitions are:
- RUN→PENDING on a request without completion.
- RUN→STOPPED on a request together with completion.
- PENDING→STOPPED on completion.
- STOPPED→RUN on resume.

Serializer states: IDLE (shows breakpoint status) and SHIFT (streams nibbles). Its transitions are:
- IDLE→SHIFT on an accepted request.
- SHIFT→SHIFT after the last nibble when a held or new request exists.
- SHIFT→IDLE after the last nibble when no request exists.

Top module: `pst_trace_unit`

## Requirements
- R1: While not halted, `status_out` equals the `core_status` value sampled at the previous rising clock edge (one register stage).
- R2: When `brk_req` is seen without `instr_done`, the status keeps following the core. This holds until `instr_done` is sampled high, and the request need not stay asserted. After that edge the status shows 0xF. If `brk_req` and `instr_done` are high at the same edge, the status shows 0xF right after that edge.
- R3: While halted, `status_out` is 4'hF whatever `core_status` does, and a further `brk_req` has no effect.
- R4: While not halted, a `core_status` of 4'hF is output as 4'h0, so 0xF appears only for a halt.
- R5: `resume` sampled high while halted ends the halt. `status_out` then equals the `core_status` sampled at that same edge.
- R6: With no value streaming, `ddata_out` equals the `bkpt_status` sampled at the previous edge.
- R7: `cap_mode` bit 0 enables address capture (`addr_req`) and bit 1 enables operand capture (`oper_req`). A disabled request is ignored, and `ddata_out` keeps showing breakpoint status.
- R8: `wdd_req` is accepted for any `cap_mode`. When several accepted requests coincide, the write-debug-data value wins, then the operand value, then the address value.
- R9: An accepted 32-bit value appears on `ddata_out` as bits [3:0], [7:4], …, [31:28] on eight consecutive cycles, starting just after the accepting edge. Breakpoint status returns on the cycle after the last nibble.
- R10: A request accepted while a value is streaming is held. Its eight nibbles follow the current value's last nibble with no gap.
- R11: While the holding register is full, further accepted requests are dropped.
- R12: During reset `status_out` and `ddata_out` are 0, the halt controller is in RUN and the serializer is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_status | input | 4 | Core's per-cycle pipeline code |
| brk_req | input | 1 | Manual breakpoint request |
| instr_done | input | 1 | Current instruction has completed |
| resume | input | 1 | Leave the halted state |
| bkpt_status | input | 4 | Breakpoint status bits |
| cap_mode | input | 2 | Bit 0 enables address capture, bit 1 enables operand capture |
| addr_req | input | 1 | Address capture request |
| addr_value | input | 32 | Address to capture |
| oper_req | input | 1 | Operand capture request |
| oper_value | input | 32 | Operand to capture |
| wdd_req | input | 1 | Write-debug-data request, always accepted |
| wdd_value | input | 32 | Write-debug-data operand |
| status_out | output | 4 | Processor status code to the probe |
| ddata_out | output | 4 | Debug-data nibble to the probe |

## Verification
The assertions check the following on every cycle:
- the halt code appears exactly when the controller is STOPPED, and never otherwise;
- no halt happens without an instruction completion;
- a resume returns the status bus to the core code;
- an IDLE serializer mirrors the breakpoint bits;
- a stream never ends before its eighth nibble;
- a full holding register is never overwritten.

Only the bench's scenarios can show the rest:
- the exact nibble order;
- the gating by each `cap_mode` setting for each request kind;
- the priority among simultaneous requests;
- the back-to-back timing of a held value;
- that a third request is lost.

// File: rtl/pst_trace_pkg.sv
package pst_trace_pkg;

    typedef enum logic [1:0] {
        HALT_RUN     = 2'd0,
        HALT_PENDING = 2'd1,
        HALT_STOPPED = 2'd2
    } halt_state_e;

    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

endpackage

// File: rtl/pst_halt_ctrl.sv
module pst_halt_ctrl
    import pst_trace_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] core_status,
    input  logic              brk_req,
    input  logic              instr_done,
    input  logic              resume,
    output logic [CODE_W-1:0] status_out
);

    localparam logic [CODE_W-1:0] HALT_CODE  = '1;
    localparam logic [CODE_W-1:0] SUBST_CODE = '0;

    halt_state_e       state_q, state_d;
    logic [CODE_W-1:0] status_q, status_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALT_RUN: begin
                if (brk_req && instr_done)  state_d = HALT_STOPPED;
                else if (brk_req)           state_d = HALT_PENDING;
            end
            HALT_PENDING: begin
                if (instr_done)             state_d = HALT_STOPPED;
            end
            HALT_STOPPED: begin
                if (resume)                 state_d = HALT_RUN;
            end
            default:                        state_d = HALT_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HALT_RUN;
        else        state_q <= state_d;
    end

    // output logic: halt code is reserved for the stopped state
    always_comb begin
        if (state_d == HALT_STOPPED)       status_d = HALT_CODE;
        else if (core_status == HALT_CODE) status_d = SUBST_CODE;
        else                               status_d = core_status;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status_out = status_q;

    assert_halt_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HALT_STOPPED) |-> (status_out == HALT_CODE));

    assert_code_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HALT_STOPPED) |-> (status_out != HALT_CODE));

    assert_wait_completion_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != HALT_STOPPED && !instr_done) |=> (state_q != HALT_STOPPED));

    assert_resume_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HALT_STOPPED && resume && core_status != HALT_CODE)
        |=> (status_out == $past(core_status)));

endmodule

// File: rtl/pst_ddata_serializer.sv
module pst_ddata_serializer
    import pst_trace_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NIB_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NIB_W-1:0]  bkpt_status,
    input  logic              cap_req,
    input  logic [DATA_W-1:0] cap_value,
    output logic [NIB_W-1:0]  ddata_out
);

    localparam int NIBBLES = DATA_W / NIB_W;
    localparam int CNT_W   = $clog2(NIBBLES + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(NIBBLES);

    ser_state_e        state_q, state_d;
    logic [DATA_W-1:0] shreg_q, shreg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              hold_vld_q, hold_vld_d;
    logic [DATA_W-1:0] hold_val_q, hold_val_d;
    logic [NIB_W-1:0]  ddata_q, ddata_d;

    logic              last_nib;
    logic              do_load;
    logic [DATA_W-1:0] load_val;

    assign last_nib = (cnt_q == LAST_CNT);

    // transition and holding-register decisions
    always_comb begin
        state_d    = state_q;
        hold_vld_d = hold_vld_q;
        hold_val_d = hold_val_q;
        do_load    = 1'b0;
        load_val   = cap_value;
        unique case (state_q)
            SER_IDLE: begin
                if (cap_req) begin
                    do_load = 1'b1;
                    state_d = SER_SHIFT;
                end
            end
            SER_SHIFT: begin
                if (last_nib) begin
                    if (hold_vld_q) begin
                        do_load    = 1'b1;
                        load_val   = hold_val_q;
                        hold_vld_d = cap_req;
                        if (cap_req) hold_val_d = cap_value;
                    end else if (cap_req) begin
                        do_load = 1'b1;
                    end else begin
                        state_d = SER_IDLE;
                    end
                end else if (cap_req && !hold_vld_q) begin
                    hold_vld_d = 1'b1;
                    hold_val_d = cap_value;
                end
            end
            default: state_d = SER_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SER_IDLE;
            hold_vld_q <= 1'b0;
            hold_val_q <= '0;
        end else begin
            state_q    <= state_d;
            hold_vld_q <= hold_vld_d;
            hold_val_q <= hold_val_d;
        end
    end

    // output and shift path
    always_comb begin
        shreg_d = shreg_q;
        cnt_d   = cnt_q;
        ddata_d = bkpt_status;
        if (do_load) begin
            ddata_d = load_val[NIB_W-1:0];
            shreg_d = load_val >> NIB_W;
            cnt_d   = CNT_W'(1);
        end else if (state_q == SER_SHIFT && !last_nib) begin
            ddata_d = shreg_q[NIB_W-1:0];
            shreg_d = shreg_q >> NIB_W;
            cnt_d   = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            ddata_q <= '0;
        end else begin
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
            ddata_q <= ddata_d;
        end
    end

    assign ddata_out = ddata_q;

    logic armed_q;
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_idle_shows_bkpt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && state_q == SER_IDLE) |-> (ddata_out == $past(bkpt_status)));

    assert_no_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SER_SHIFT && !last_nib) |=> (state_q == SER_SHIFT));

    assert_hold_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld_q && state_q == SER_SHIFT && !last_nib)
        |=> (hold_vld_q && $stable(hold_val_q)));

endmodule

// File: rtl/pst_trace_unit.sv
module pst_trace_unit
    import pst_trace_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] core_status,
    input  logic              brk_req,
    input  logic              instr_done,
    input  logic              resume,
    input  logic [CODE_W-1:0] bkpt_status,
    input  logic [1:0]        cap_mode,
    input  logic              addr_req,
    input  logic [DATA_W-1:0] addr_value,
    input  logic              oper_req,
    input  logic [DATA_W-1:0] oper_value,
    input  logic              wdd_req,
    input  logic [DATA_W-1:0] wdd_value,
    output logic [CODE_W-1:0] status_out,
    output logic [CODE_W-1:0] ddata_out
);

    logic              addr_ok, oper_ok, cap_req;
    logic [DATA_W-1:0] cap_value;

    assign addr_ok = addr_req && cap_mode[0];
    assign oper_ok = oper_req && cap_mode[1];
    assign cap_req = wdd_req || oper_ok || addr_ok;

    // priority: write-debug-data, then operand, then address
    always_comb begin
        if (wdd_req)      cap_value = wdd_value;
        else if (oper_ok) cap_value = oper_value;
        else              cap_value = addr_value;
    end

    pst_halt_ctrl #(.CODE_W(CODE_W)) u_halt (
        .clk         (clk),
        .rst_n       (rst_n),
        .core_status (core_status),
        .brk_req     (brk_req),
        .instr_done  (instr_done),
        .resume      (resume),
        .status_out  (status_out)
    );

    pst_ddata_serializer #(.DATA_W(DATA_W), .NIB_W(CODE_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bkpt_status (bkpt_status),
        .cap_req     (cap_req),
        .cap_value   (cap_value),
        .ddata_out   (ddata_out)
    );

endmodule

// File: tb/pst_trace_unit_bench.sv
`timescale 1ns/1ps
module pst_trace_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  core_status, bkpt_status;
    logic        brk_req, instr_done, resume;
    logic [1:0]  cap_mode;
    logic        addr_req, oper_req, wdd_req;
    logic [31:0] addr_value, oper_value, wdd_value;
    logic [3:0]  status_out, ddata_out;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pst_trace_unit u_pst_trace_unit (
        .clk(clk), .rst_n(rst_n), .core_status(core_status),
        .brk_req(brk_req), .instr_done(instr_done), .resume(resume),
        .bkpt_status(bkpt_status), .cap_mode(cap_mode),
        .addr_req(addr_req), .addr_value(addr_value),
        .oper_req(oper_req), .oper_value(oper_value),
        .wdd_req(wdd_req), .wdd_value(wdd_value),
        .status_out(status_out), .ddata_out(ddata_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] nib(input logic [31:0] v, input int i);
        return 4'((v >> (4 * i)) & 32'hF);
    endfunction

    // stream check: after the accepting edge, eight nibbles then breakpoint status
    task automatic expect_stream(input logic [31:0] v, input string tag);
        for (int i = 0; i < 8; i++) begin
            if (i > 0) step();
            chk(ddata_out, nib(v, i), tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; core_status = 4'h3; bkpt_status = 4'h6;
        brk_req = 0; instr_done = 0; resume = 0; cap_mode = 2'b00;
        addr_req = 0; oper_req = 0; wdd_req = 0;
        addr_value = '0; oper_value = '0; wdd_value = '0;
        repeat (3) step();
        chk(status_out, 4'h0, "R12 status reset");
        chk(ddata_out, 4'h0, "R12 ddata reset");
        rst_n = 1'b1;

        // R1, R4, R6: sweep all status and breakpoint codes
        for (int c = 0; c < 16; c++) begin
            core_status = 4'(c);
            bkpt_status = 4'(c) ^ 4'h5;
            step();
            chk(status_out, (c == 15) ? 4'h0 : 4'(c), (c == 15) ? "R4 reserved code" : "R1 status follow");
            chk(ddata_out, 4'(c) ^ 4'h5, "R6 bkpt default");
        end

        // R7, R8, R9: every mode against every request kind
        bkpt_status = 4'hA;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                logic [31:0] v;
                logic acc;
                v = 32'h9E37_79B9 * 32'(m * 3 + k + 1);
                acc = (k == 2) || (k == 1 && m[1]) || (k == 0 && m[0]);
                cap_mode = 2'(m);
                addr_value = v; oper_value = v; wdd_value = v;
                addr_req = (k == 0); oper_req = (k == 1); wdd_req = (k == 2);
                step();
                addr_req = 0; oper_req = 0; wdd_req = 0;
                if (acc) expect_stream(v, (k == 2) ? "R8 wdd stream" : "R9 capture stream");
                else begin
                    for (int i = 0; i < 8; i++) begin
                        if (i > 0) step();
                        chk(ddata_out, 4'hA, "R7 disabled ignored");
                    end
                end
                step();
                chk(ddata_out, 4'hA, "R9 bkpt after last");
            end
        end

        // R8 priority
        cap_mode = 2'b11;
        addr_value = 32'h1111_1111; oper_value = 32'h2222_2222; wdd_value = 32'h3333_3333;
        addr_req = 1; oper_req = 1; wdd_req = 1;
        step();
        addr_req = 0; oper_req = 0; wdd_req = 0;
        expect_stream(32'h3333_3333, "R8 wdd priority");
        step(); chk(ddata_out, 4'hA, "R8 end");
        addr_req = 1; oper_req = 1;
        step();
        addr_req = 0; oper_req = 0;
        expect_stream(32'h2222_2222, "R8 operand priority");
        step(); chk(ddata_out, 4'hA, "R8 end");

        // R10, R11: queued request and a dropped third one
        wdd_value = 32'hFEDC_BA98; wdd_req = 1;
        step(); wdd_req = 0;
        chk(ddata_out, 4'h8, "R9 first nibble");
        step(); chk(ddata_out, 4'h9, "R9 nibble1");
        wdd_value = 32'h0135_7ACE; wdd_req = 1;
        step(); chk(ddata_out, 4'hA, "R9 nibble2");
        wdd_value = 32'h5555_5555;
        step(); chk(ddata_out, 4'hB, "R9 nibble3");
        wdd_req = 0;
        for (int i = 4; i < 8; i++) begin
            step(); chk(ddata_out, nib(32'hFEDC_BA98, i), "R9 first value");
        end
        step();
        expect_stream(32'h0135_7ACE, "R10 held value");
        step(); chk(ddata_out, 4'hA, "R11 third dropped");

        // R2, R3, R5: delayed halt
        core_status = 4'h3; brk_req = 1; instr_done = 0;
        step(); chk(status_out, 4'h3, "R2 waits for completion");
        brk_req = 0;
        step(); chk(status_out, 4'h3, "R2 pending");
        instr_done = 1;
        step(); chk(status_out, 4'hF, "R2 halt on completion");
        instr_done = 0; core_status = 4'h7;
        step(); chk(status_out, 4'hF, "R3 halted");
        brk_req = 1;
        step(); chk(status_out, 4'hF, "R3 brk ignored");
        brk_req = 0; resume = 1; core_status = 4'h5;
        step(); chk(status_out, 4'h5, "R5 resume");
        resume = 0; core_status = 4'h2;
        step(); chk(status_out, 4'h2, "R5 running");

        // R2 immediate halt
        brk_req = 1; instr_done = 1;
        step(); chk(status_out, 4'hF, "R2 immediate");
        brk_req = 0; instr_done = 0; resume = 1; core_status = 4'h9;
        step(); chk(status_out, 4'h9, "R5 resume again");
        resume = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule